// File: doc/BRIEF.md
# Programmable Interval Timer with Prescaler

This block is a 16-bit down-counting timer that raises a level interrupt each time its count runs out. Software reaches three registers over a 16-bit bus: a control/status word, a modulus value and a read-only view of the live count. Each register is selected by a byte offset. Writes take effect on a clock edge when the write strobe is high. Read data is a combinational function of the offset.

The count steps once per tick. A tick comes every 2·2^P system clock cycles, where P is a 4-bit prescale field, so the divisor runs from 2 up to 65536. When the count runs out it either reloads from the modulus register (reload mode) or wraps to 0xFFFF (free-running mode). In both cases it sets a sticky interrupt flag, which software clears by writing a one to it.

A control write that only touches the interrupt enable or the flag leaves the count and the prescaler running undisturbed. Any other control write restarts both. An overwrite bit decides whether a modulus write loads the count at once or waits for the next reload.

Top module: `pit_timer`

## Requirements
- R1: Offsets are byte addresses. Offset 0 reads the control word, offset 2 reads the modulus and offset 4 reads the live count. Every other offset reads zero. In the control word, the bits 7 and 15:12 read zero. A control write of 0xFFFF therefore reads back as 0x0F7B.
- R2: Writes to offset 4 and to unmapped offsets change no register and no count.
- R3: While enabled, a tick occurs every 2·2^P clock cycles, where P is control bits 11:8. The first tick comes 2·2^P cycles after the last restart or overwrite load.
- R4: Reload mode is control bit 1. On a tick with the count at zero, reload mode loads the modulus and sets the flag (bit 2). On a tick with any other count, the count decrements by one. The first terminal event therefore comes (M+1)·2·2^P cycles after a restart.
- R5: With bit 1 clear, a tick at count zero loads 0xFFFF and sets the flag.
- R6: Writing 1 to control bit 2 clears the flag. Writing 0 to it leaves the flag unchanged. No write can set the flag.
- R7: The output irq is high exactly when the flag (bit 2) and the interrupt enable (bit 3) are both set.
- R8: A control write whose stored bits differ from the current control word only in bits 2 and 3 leaves the count and the prescaler phase undisturbed.
- R9: Any other control write clears the prescaler. It loads the count with the new limit: the modulus if the new bit 1 is set, 0xFFFF otherwise.
- R10: A modulus write clears the flag. If the overwrite bit (bit 4) is set, the write also loads the count with the written value and clears the prescaler.
- R11: A modulus write with bit 4 clear leaves the count unchanged. In reload mode, the new value is used at the next reload.
- R12: While enable (bit 0) is clear, the count holds and the flag is not set.
- R13: After reset, the control word and modulus read 0, the count reads 0xFFFF and irq is low.
- R14: Bits 5 and 6 are stored and read back but do not alter counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit count, a 4-bit prescale field and a 3-bit offset. It drives only prescale values 0 to 3. These short tick periods let it sweep every combination of those prescales with modulus values 0, 1, 2 and 5, observing the cycle of each terminal event exactly. The full 0xFFFF wrap is reached by loading a small count through the overwrite path rather than waiting out the whole range. This keeps free-running wrap, flag clearing and restart-versus-no-restart control writes all within a short run.

// File: rtl/pit_pkg.sv
// Package: shared offsets and control-word bit positions for the interval timer.
// Assumes a 16-bit control word with the layout described in the brief.
package pit_pkg;
    localparam int CTRL_W = 16;

    localparam int B_EN   = 0;
    localparam int B_RLD  = 1;
    localparam int B_FLAG = 2;
    localparam int B_IE   = 3;
    localparam int B_OVW  = 4;
    localparam int B_DBG  = 5;
    localparam int B_DOZE = 6;
    localparam int B_PRE  = 8;

    // Bits that are stored (flag is stored separately by event logic).
    localparam logic [CTRL_W-1:0] STORE_MASK   = 16'h0F7B;
    // Stored bits whose change forces a restart (all but interrupt enable).
    localparam logic [CTRL_W-1:0] RESTART_MASK = 16'h0F73;

    localparam logic [2:0] OFS_CTRL = 3'd0;
    localparam logic [2:0] OFS_MOD  = 3'd2;
    localparam logic [2:0] OFS_CNT  = 3'd4;
endpackage

// File: rtl/pit_regs.sv
// Module: control word and modulus storage with the flag event logic.
// Assumes one register write per cycle. A terminal event wins over a clear in the same cycle.
module pit_regs
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_mod,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              terminal,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [CNT_W-1:0]  mod_q,
    output logic              restart,
    output logic              restart_rld,
    output logic              ovw_load
);
    logic              flag_q;
    logic [CTRL_W-1:0] bits_q;
    logic              flag_d;

    // Decode which write side effects happen this cycle.
    always_comb begin
        restart     = wr_ctrl && (((wdata ^ bits_q) & RESTART_MASK) != '0);
        restart_rld = wdata[B_RLD];
        ovw_load    = wr_mod && bits_q[B_OVW];
    end

    // Next flag: cleared by a one written to it or by a modulus write, set by a terminal event.
    always_comb begin
        flag_d = flag_q;
        if (wr_ctrl && wdata[B_FLAG]) flag_d = 1'b0;
        if (wr_mod)                   flag_d = 1'b0;
        if (terminal)                 flag_d = 1'b1;
    end

    // Register the control bits, flag and modulus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
            flag_q <= 1'b0;
            mod_q  <= '0;
        end else begin
            flag_q <= flag_d;
            if (wr_ctrl) bits_q <= wdata & STORE_MASK;
            if (wr_mod)  mod_q  <= wdata[CNT_W-1:0];
        end
    end

    // Assemble the visible control word.
    always_comb begin
        ctrl_q         = bits_q;
        ctrl_q[B_FLAG] = flag_q;
    end
endmodule

// File: rtl/pit_prescaler.sv
// Module: divides the clock by 2*2^pre to produce a single-cycle tick.
// Assumes pre changes only together with a clear; it holds its phase while disabled.
module pit_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    localparam int DIV_W = (1 << PRE_W);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] last;
    logic [DIV_W-1:0] one;

    // Terminal value of the divider for the current prescale.
    always_comb begin
        one  = {{(DIV_W-1){1'b0}}, 1'b1};
        last = (one << ({1'b0, pre} + 1'b1)) - one;
        tick = en && (div_q == last);
    end

    // Step the divider while enabled; clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  div_q <= '0;
        else if (tick)      div_q <= '0;
        else if (en)        div_q <= div_q + one;
    end
endmodule

// File: rtl/pit_counter.sv
// Module: the down counter with restart, overwrite load and terminal reload.
// Assumes restart and overwrite load never coincide. A load suppresses a same-cycle tick.
module pit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rld,
    input  logic [CNT_W-1:0] mod_val,
    input  logic             restart,
    input  logic             restart_rld,
    input  logic             ovw_load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             terminal
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] restart_limit;

    // Pick reload limits and flag the terminal event.
    always_comb begin
        limit         = rld ? mod_val : ALL_ONES;
        restart_limit = restart_rld ? mod_val : ALL_ONES;
        terminal      = tick && (cnt_q == '0) && !restart && !ovw_load;
    end

    // Update the count by priority: restart, overwrite, tick.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= ALL_ONES;
        else if (restart)         cnt_q <= restart_limit;
        else if (ovw_load)        cnt_q <= load_val;
        else if (terminal)        cnt_q <= limit;
        else if (tick)            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/pit_timer.sv
// Module: top of the interval timer with register decode and read mux.
// Assumes byte offsets on bus_addr and a single-cycle write strobe.
module pit_timer
    import pit_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 4,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    logic              wr_ctrl;
    logic              wr_mod;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  mod_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              restart;
    logic              restart_rld;
    logic              ovw_load;
    logic              tick;
    logic              terminal;

    // Decode write targets.
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
        wr_mod  = bus_wr && (bus_addr == ADDR_W'(OFS_MOD));
    end

    pit_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_mod(wr_mod),
        .wdata(bus_wdata), .terminal(terminal), .ctrl_q(ctrl_q), .mod_q(mod_q),
        .restart(restart), .restart_rld(restart_rld), .ovw_load(ovw_load)
    );

    pit_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q[B_EN]), .clr(restart || ovw_load),
        .pre(ctrl_q[B_PRE +: PRE_W]), .tick(tick)
    );

    pit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rld(ctrl_q[B_RLD]),
        .mod_val(mod_q), .restart(restart), .restart_rld(restart_rld),
        .ovw_load(ovw_load), .load_val(bus_wdata), .cnt_q(cnt_q),
        .terminal(terminal)
    );

    // Read mux over the three mapped offsets.
    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_CTRL): bus_rdata = ctrl_q;
            ADDR_W'(OFS_MOD):  bus_rdata = mod_q;
            ADDR_W'(OFS_CNT):  bus_rdata = cnt_q;
            default:           bus_rdata = '0;
        endcase
    end

    // Level interrupt request.
    always_comb irq = ctrl_q[B_FLAG] && ctrl_q[B_IE];
endmodule

// File: rtl/pit_timer_chk.sv
// Module: temporal checks on the interval timer, bound to its top.
// Assumes the signal names of pit_timer.
module pit_timer_chk
    import pit_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              irq,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic [CNT_W-1:0]  mod_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              tick
);
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[B_EN] && !bus_wr) |=> $stable(cnt_q)); // R12
    AST_NO_FLAG_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[B_EN] && !ctrl_q[B_FLAG]) |=> !ctrl_q[B_FLAG]); // R12
    AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !bus_wr) |=> $stable(cnt_q)); // R3
    AST_TICK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q != '0 && !bus_wr) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
    AST_FLAG_ON_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == '0 && !bus_wr) |=> ctrl_q[B_FLAG]); // R4
    AST_MOD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_MOD)) |=> !ctrl_q[B_FLAG]); // R10
    AST_CNT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_CNT)) |=>
        ($stable(mod_q) && $stable(ctrl_q & STORE_MASK))); // R2
    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_q[B_IE]); // R7
endmodule

bind pit_timer pit_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .irq(irq),
    .ctrl_q(ctrl_q), .mod_q(mod_q), .cnt_q(cnt_q), .tick(tick)
);

// File: tb/tb_pit_timer.sv
`timescale 1ns/1ps
// Bench: sweeps prescale and modulus, then walks the corner cases of each requirement.
module tb_pit_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;
    int checks = 0;
    int errors = 0;
    logic [15:0] v;

    pit_timer dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
                   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h expected=%h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] rld_count(input int m, input int t, input int n);
        return 16'(m - ((n / t) % (m + 1)));
    endfunction

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R13 reset state
        rd(0, v); chk("R13 ctrl", v, 16'h0000);
        rd(2, v); chk("R13 mod", v, 16'h0000);
        rd(4, v); chk("R13 cnt", v, 16'hFFFF);
        chk("R13 irq", {15'd0, irq}, 16'd0);

        // R1 and R14 readback, R10 overwrite load
        wr(0, 16'hFFFF);
        rd(0, v); chk("R1 R14 ctrl readback", v, 16'h0F7B);
        wr(2, 16'hABCD);
        rd(2, v); chk("R1 mod readback", v, 16'hABCD);
        rd(4, v); chk("R10 overwrite load", v, 16'hABCD);
        rd(1, v); chk("R1 unmapped 1", v, 16'h0000);
        rd(6, v); chk("R1 unmapped 6", v, 16'h0000);
        // R2 ignored writes
        wr(6, 16'h1111);
        wr(4, 16'h2222);
        rd(0, v); chk("R2 ctrl kept", v, 16'h0F7B);
        rd(2, v); chk("R2 mod kept", v, 16'hABCD);
        rd(4, v); chk("R2 cnt kept", v, 16'hABCD);
        wr(0, 16'h0000);

        // R6 software cannot set the flag
        wr(0, 16'h0004);
        rd(0, v); chk("R6 no set", v, 16'h0000);

        // R3 R4 R7 R6 R8 sweep over prescale and modulus
        for (int p = 0; p < 4; p++) begin
            for (int mi = 0; mi < 4; mi++) begin
                int m;
                int t;
                logic ie;
                logic [15:0] cw;
                m  = (mi == 3) ? 5 : mi;
                t  = 2 << p;
                ie = mi[0];
                cw = 16'h0003 | (16'(ie) << 3) | (16'(p) << 8);
                wr(2, 16'(m));
                wr(0, cw);
                wait_cyc(t * (m + 1) - 1);
                rd(4, v); chk("R3 R4 count before terminal", v, 16'h0000);
                rd(0, v); chk("R4 flag before terminal", {15'd0, v[2]}, 16'd0);
                chk("R7 irq low", {15'd0, irq}, 16'd0);
                wait_cyc(1);
                rd(4, v); chk("R4 reload", v, 16'(m));
                rd(0, v); chk("R4 flag set", {15'd0, v[2]}, 16'd1);
                chk("R7 irq level", {15'd0, irq}, {15'd0, ie});
                wr(0, cw | 16'h0004);
                rd(0, v); chk("R6 flag cleared", {15'd0, v[2]}, 16'd0);
                rd(4, v); chk("R8 flag clear keeps count", v, rld_count(m, t, t * (m + 1) + 1));
                wr(0, 16'h0000);
            end
        end

        // R8 interrupt-enable toggle does not restart; R9 other change does
        wr(2, 16'd5);
        wr(0, 16'h0103);
        wait_cyc(6);
        wr(0, 16'h010B);
        wait_cyc(3);
        rd(4, v); chk("R8 ie toggle no restart", v, rld_count(5, 4, 10));
        wr(0, 16'h0003);
        rd(4, v); chk("R9 restart loads modulus", v, 16'd5);
        wait_cyc(2);
        rd(4, v); chk("R9 prescaler cleared", v, 16'd4);

        // R11 modulus write without overwrite in reload mode
        wr(2, 16'd2);
        rd(4, v); chk("R11 count unchanged", v, 16'd4);
        wait_cyc(9);
        rd(4, v); chk("R11 new modulus at reload", v, 16'd2);
        rd(0, v); chk("R4 flag at reload", {15'd0, v[2]}, 16'd1);
        wr(2, 16'd2);
        rd(0, v); chk("R10 modulus write clears flag", {15'd0, v[2]}, 16'd0);

        // R5 free-running wrap via overwrite
        wr(0, 16'h0011);
        wr(2, 16'd2);
        wait_cyc(5);
        rd(4, v); chk("R5 count zero", v, 16'h0000);
        wait_cyc(1);
        rd(4, v); chk("R5 wrap to all ones", v, 16'hFFFF);
        rd(0, v); chk("R5 flag set", {15'd0, v[2]}, 16'd1);
        chk("R7 irq masked", {15'd0, irq}, 16'd0);

        // R11 free-running modulus write without overwrite
        wr(0, 16'h0001);
        wr(2, 16'd7);
        rd(4, v); chk("R11 free count unchanged", v, 16'hFFFF);

        // R12 disabled hold
        wr(0, 16'h0002);
        wait_cyc(20);
        rd(4, v); chk("R12 count holds", v, 16'd7);
        rd(0, v); chk("R12 no flag", v, 16'h0002);

        // R14 debug and doze bits do not alter counting
        wr(2, 16'd3);
        wr(0, 16'h0063);
        wait_cyc(7);
        rd(4, v); chk("R14 count zero", v, 16'h0000);
        wait_cyc(1);
        rd(4, v); chk("R14 reload", v, 16'd3);
        rd(0, v); chk("R14 readback", v, 16'h0067);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule